// File: doc/BRIEF.md
# RTC Time Snapshot Sequencer

This block runs whole calendar transactions against a small clock chip whose registers are four bits wide. It sits above a serial register master: it issues one register read or write at a time over a request/acknowledge pair, raises the chip-enable request for the length of a transaction, and leaves the bit-level serial timing to the master. The host sees a binary time bundle, `get`, `set` and `init` strobes, a valid flag, an error flag and a one-cycle done pulse.

Each decimal field of the chip is held as a ones nibble and a tens nibble at consecutive addresses. Before any get or set, the block writes the base control value and reads the control register back. If the busy bit is set it drops chip enable, waits, and tries again, up to a bounded number of attempts. The init strobe checks the oscillator-stop flag. If the flag is clear the stored time is declared valid. If it is set, the block clears the timer-interrupt register and runs an adjust cycle that is polled against busy. Gets issued while the time is not valid return at once and touch nothing.

Top module: `rtc_snap_seq`

## Requirements
- R1: After reset, chip_ce, bus_req, done, time_valid and err are all 0.
- R2: On init, the control register (address 15) is read once. If its stop flag (bit 3) is clear, time_valid becomes 1 and no further access is made.
- R3: On init with the stop flag set, time_valid becomes 0 and the block does the following in order: writes 0 to the timer register (address 14), writes the base value 4 with the adjust bit (bit 0) set, polls control reads until busy (bit 1) is clear, then writes the base value 4.
- R4: During init, at most INIT_POLLS (1000) busy polls are made. If all of them see busy, err is set and the final base write is skipped.
- R5: Each get or set attempt writes base 4 to control and then reads control back. A busy readback drops chip_ce, waits, and starts a new attempt. A readback on the last allowed attempt (the 10th) that is clear still proceeds.
- R6: If all SYNC_TRIES (10) attempts read busy, err is set and no field register is accessed.
- R7: A get reads addresses 0 to 11 in ascending order and then address 12. The pairs are seconds, minutes, hours, day, month and year, with the ones nibble at the even address and the tens nibble at the odd one. Address 12 is the weekday.
- R8: Each returned field equals tens times ten plus ones. The weekday is returned as the raw nibble.
- R9: A set writes the BCD digits of each field to the same addresses in the same order as a get: the low digit to the ones register and the high digit to the tens register. The weekday is written last.
- R10: A field value is reduced modulo 100 before conversion, so a year of 123 is stored as 2 and 3.
- R11: A get while time_valid is 0 produces done with no bus request and no chip_ce.
- R12: A set that completes its field writes sets time_valid to 1.
- R13: chip_ce is low when done pulses. done lasts exactly one cycle, and bus_req is only raised while chip_ce is high.
- R14: Strobes arriving together are served in the priority init, then set, then get. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start the stop-flag check and adjust sequence |
| get_req | input | 1 | Start a time read |
| set_req | input | 1 | Start a time write using the set_* inputs |
| set_sec | input | 7 | Seconds to write, binary |
| set_min | input | 7 | Minutes to write, binary |
| set_hour | input | 7 | Hours to write, binary |
| set_day | input | 7 | Day of month to write, binary |
| set_mon | input | 7 | Month to write, binary |
| set_year | input | 7 | Year to write, binary, stored modulo 100 |
| set_wday | input | 3 | Weekday to write |
| get_sec | output | 7 | Seconds from the last good get |
| get_min | output | 7 | Minutes from the last good get |
| get_hour | output | 7 | Hours from the last good get |
| get_day | output | 7 | Day from the last good get |
| get_mon | output | 7 | Month from the last good get |
| get_year | output | 7 | Two-digit year from the last good get |
| get_wday | output | 4 | Weekday nibble from the last good get |
| time_valid | output | 1 | The time held by the chip is trusted |
| err | output | 1 | The last transaction timed out on busy |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| chip_ce | output | 1 | Chip-enable request to the serial master |
| bus_req | output | 1 | Register access request, held until bus_ack |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 4 | Write nibble |
| bus_ack | input | 1 | One-cycle completion of the current access |
| bus_rdata | input | 4 | Read nibble, valid with bus_ack |

## Verification
The bench pushes both retry loops to their exact edges. Nine busy readbacks followed by a clear one must still lead to the field transfer. Ten busy readbacks must end with err and no field access. An off-by-one limit would either give up one attempt early or start an eleventh. The init adjust case is run with 1000 busy polls, and a counter that is wrong by one changes the logged count of control reads. A set with year 123 followed by a get catches a design that drops the modulo or swaps ones and tens, because both the logged write nibbles and the returned value would be off. A get before the time is valid, and strobes that arrive together, confirm that the chip is never touched when it must not be.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
  localparam int NFIELD = 6;
  localparam int NREG   = 2 * NFIELD + 1;
  localparam int FW     = 7;
  localparam int WW     = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT_CHK,
    ST_INIT_TINT,
    ST_INIT_ADJ,
    ST_INIT_POLL,
    ST_INIT_WAIT,
    ST_INIT_BASE,
    ST_SYNC_WR,
    ST_SYNC_RD,
    ST_SYNC_WAIT,
    ST_XFER,
    ST_FINISH
  } seq_state_t;
endpackage

// File: rtl/rtc_wait_timer.sv
module rtc_wait_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CNTW = $clog2(CYCLES + 1);

  logic            run;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt == CNTW'(CYCLES - 1)) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_pack.sv
module rtc_bcd_pack
  import rtc_seq_pkg::*;
(
  input  logic [NFIELD*FW-1:0] bin,
  input  logic [WW-1:0]        wday,
  output logic [NREG*4-1:0]    nib
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    logic [FW-1:0] red;
    assign red = bin[g*FW +: FW] % FW'(100);
    assign nib[(2*g)*4 +: 4]   = 4'(red % FW'(10));
    assign nib[(2*g+1)*4 +: 4] = 4'(red / FW'(10));
  end
  assign nib[NREG*4-1 -: 4] = {{(4-WW){1'b0}}, wday};
endmodule

// File: rtl/rtc_field_decode.sv
module rtc_field_decode
  import rtc_seq_pkg::*;
(
  input  logic [NREG*4-1:0]    nib,
  output logic [NFIELD*FW-1:0] bin,
  output logic [3:0]           wday
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign bin[g*FW +: FW] = FW'(nib[(2*g+1)*4 +: 4]) * FW'(10) + FW'(nib[(2*g)*4 +: 4]);
  end
  assign wday = nib[NREG*4-1 -: 4];
endmodule

// File: rtl/rtc_snap_seq.sv
module rtc_snap_seq
  import rtc_seq_pkg::*;
#(
  parameter int         WAIT_CYCLES = 8,
  parameter int         SYNC_TRIES  = 10,
  parameter int         INIT_POLLS  = 1000,
  parameter logic [3:0] ADDR_SEC    = 4'd0,
  parameter logic [3:0] ADDR_MIN    = 4'd2,
  parameter logic [3:0] ADDR_HOUR   = 4'd4,
  parameter logic [3:0] ADDR_DAY    = 4'd6,
  parameter logic [3:0] ADDR_MON    = 4'd8,
  parameter logic [3:0] ADDR_YEAR   = 4'd10,
  parameter logic [3:0] ADDR_WDAY   = 4'd12,
  parameter logic [3:0] ADDR_TINT   = 4'd14,
  parameter logic [3:0] ADDR_CTRL   = 4'd15,
  parameter logic [3:0] CTRL_BASE   = 4'b0100,
  parameter int         ADJ_BIT     = 0,
  parameter int         BSY_BIT     = 1,
  parameter int         XSTP_BIT    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          get_req,
  input  logic          set_req,
  input  logic [FW-1:0] set_sec,
  input  logic [FW-1:0] set_min,
  input  logic [FW-1:0] set_hour,
  input  logic [FW-1:0] set_day,
  input  logic [FW-1:0] set_mon,
  input  logic [FW-1:0] set_year,
  input  logic [WW-1:0] set_wday,
  output logic [FW-1:0] get_sec,
  output logic [FW-1:0] get_min,
  output logic [FW-1:0] get_hour,
  output logic [FW-1:0] get_day,
  output logic [FW-1:0] get_mon,
  output logic [FW-1:0] get_year,
  output logic [3:0]    get_wday,
  output logic          time_valid,
  output logic          err,
  output logic          done,
  output logic          chip_ce,
  output logic          bus_req,
  output logic          bus_we,
  output logic [3:0]    bus_addr,
  output logic [3:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [3:0]    bus_rdata
);
  localparam int MAXT = (INIT_POLLS > SYNC_TRIES) ? INIT_POLLS : SYNC_TRIES;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int IW   = $clog2(NREG);
  localparam logic [3:0] CTRL_ADJ = CTRL_BASE | (4'b0001 << ADJ_BIT);

  seq_state_t  state;
  logic [CW-1:0] tries;
  logic [IW-1:0] idx;
  logic          is_set;
  logic          xfer_ok;
  logic          tmr_start;
  logic          tmr_done;
  logic [3:0]    nib [NREG];

  logic [NREG*4-1:0]    pk_nib;
  logic [NREG*4-1:0]    nib_flat;
  logic [NFIELD*FW-1:0] dec_bin;
  logic [3:0]           dec_wday;

  rtc_bcd_pack u_pack (
    .bin  ({set_year, set_mon, set_day, set_hour, set_min, set_sec}),
    .wday (set_wday),
    .nib  (pk_nib)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign nib_flat[i*4 +: 4] = nib[i];
  end

  rtc_field_decode u_dec (
    .nib  (nib_flat),
    .bin  (dec_bin),
    .wday (dec_wday)
  );

  rtc_wait_timer #(.CYCLES(WAIT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .expired (tmr_done)
  );

  // Address of the register moved in transfer step idx
  logic [3:0] xfer_addr;
  always_comb begin
    logic [3:0] base;
    case (idx[IW-1:1])
      3'd0:    base = ADDR_SEC;
      3'd1:    base = ADDR_MIN;
      3'd2:    base = ADDR_HOUR;
      3'd3:    base = ADDR_DAY;
      3'd4:    base = ADDR_MON;
      default: base = ADDR_YEAR;
    endcase
    if (idx == IW'(NREG - 1)) xfer_addr = ADDR_WDAY;
    else                      xfer_addr = base + {3'b000, idx[0]};
  end

  // Access requested by the current state
  logic       bus_state;
  logic       op_we;
  logic [3:0] op_addr;
  logic [3:0] op_wdata;
  always_comb begin
    bus_state = 1'b1;
    op_we     = 1'b0;
    op_addr   = ADDR_CTRL;
    op_wdata  = CTRL_BASE;
    case (state)
      ST_INIT_CHK, ST_INIT_POLL, ST_SYNC_RD: op_we = 1'b0;
      ST_INIT_TINT: begin
        op_we    = 1'b1;
        op_addr  = ADDR_TINT;
        op_wdata = 4'h0;
      end
      ST_INIT_ADJ: begin
        op_we    = 1'b1;
        op_wdata = CTRL_ADJ;
      end
      ST_INIT_BASE, ST_SYNC_WR: op_we = 1'b1;
      ST_XFER: begin
        op_we    = is_set;
        op_addr  = xfer_addr;
        op_wdata = nib[idx];
      end
      default: bus_state = 1'b0;
    endcase
  end

  logic acked;
  assign acked = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tries      <= '0;
      idx        <= '0;
      is_set     <= 1'b0;
      xfer_ok    <= 1'b0;
      tmr_start  <= 1'b0;
      time_valid <= 1'b0;
      err        <= 1'b0;
      done       <= 1'b0;
      chip_ce    <= 1'b0;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      get_sec    <= '0;
      get_min    <= '0;
      get_hour   <= '0;
      get_day    <= '0;
      get_mon    <= '0;
      get_year   <= '0;
      get_wday   <= '0;
      for (int i = 0; i < NREG; i++) nib[i] <= '0;
    end else begin
      done      <= 1'b0;
      tmr_start <= 1'b0;

      if (bus_state && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= op_we;
        bus_addr  <= op_addr;
        bus_wdata <= op_wdata;
      end
      if (acked) bus_req <= 1'b0;

      case (state)
        ST_IDLE: begin
          tries   <= '0;
          xfer_ok <= 1'b0;
          if (init_req) begin
            err     <= 1'b0;
            is_set  <= 1'b0;
            chip_ce <= 1'b1;
            state   <= ST_INIT_CHK;
          end else if (set_req) begin
            err    <= 1'b0;
            is_set <= 1'b1;
            for (int i = 0; i < NREG; i++) nib[i] <= pk_nib[i*4 +: 4];
            chip_ce <= 1'b1;
            state   <= ST_SYNC_WR;
          end else if (get_req) begin
            err    <= 1'b0;
            is_set <= 1'b0;
            if (time_valid) begin
              chip_ce <= 1'b1;
              state   <= ST_SYNC_WR;
            end else begin
              state <= ST_FINISH;
            end
          end
        end
        ST_INIT_CHK: if (acked) begin
          if (!bus_rdata[XSTP_BIT]) begin
            time_valid <= 1'b1;
            state      <= ST_FINISH;
          end else begin
            time_valid <= 1'b0;
            state      <= ST_INIT_TINT;
          end
        end
        ST_INIT_TINT: if (acked) state <= ST_INIT_ADJ;
        ST_INIT_ADJ:  if (acked) state <= ST_INIT_POLL;
        ST_INIT_POLL: if (acked) begin
          if (bus_rdata[BSY_BIT]) begin
            if (tries == CW'(INIT_POLLS - 1)) begin
              err   <= 1'b1;
              state <= ST_FINISH;
            end else begin
              tries     <= tries + 1'b1;
              tmr_start <= 1'b1;
              state     <= ST_INIT_WAIT;
            end
          end else begin
            state <= ST_INIT_BASE;
          end
        end
        ST_INIT_WAIT: if (tmr_done) state <= ST_INIT_POLL;
        ST_INIT_BASE: if (acked) state <= ST_FINISH;
        ST_SYNC_WR:   if (acked) state <= ST_SYNC_RD;
        ST_SYNC_RD: if (acked) begin
          if (bus_rdata[BSY_BIT]) begin
            if (tries == CW'(SYNC_TRIES - 1)) begin
              err   <= 1'b1;
              state <= ST_FINISH;
            end else begin
              tries     <= tries + 1'b1;
              chip_ce   <= 1'b0;
              tmr_start <= 1'b1;
              state     <= ST_SYNC_WAIT;
            end
          end else begin
            idx   <= '0;
            state <= ST_XFER;
          end
        end
        ST_SYNC_WAIT: if (tmr_done) begin
          chip_ce <= 1'b1;
          state   <= ST_SYNC_WR;
        end
        ST_XFER: if (acked) begin
          if (!is_set) nib[idx] <= bus_rdata;
          if (idx == IW'(NREG - 1)) begin
            xfer_ok <= 1'b1;
            state   <= ST_FINISH;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_FINISH: begin
          chip_ce <= 1'b0;
          done    <= 1'b1;
          if (xfer_ok) begin
            if (is_set) begin
              time_valid <= 1'b1;
            end else begin
              get_sec  <= dec_bin[0*FW +: FW];
              get_min  <= dec_bin[1*FW +: FW];
              get_hour <= dec_bin[2*FW +: FW];
              get_day  <= dec_bin[3*FW +: FW];
              get_mon  <= dec_bin[4*FW +: FW];
              get_year <= dec_bin[5*FW +: FW];
              get_wday <= dec_wday;
            end
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_snap_seq_chk.sv
module rtc_snap_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       chip_ce,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       bus_we,
  input logic [3:0] bus_addr,
  input logic [3:0] bus_wdata,
  input logic       done
);
  // R5: an access is held unchanged until it is acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R7: one acknowledge ends exactly one access
  p_ack_ends_r7: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  // R13: no access without chip enable
  p_req_ce_r13: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> chip_ce);

  // R13: done is a single-cycle pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13: chip enable is released by the time done is seen
  p_done_ce_r13: assert property (@(posedge clk) disable iff (rst)
    done |-> !chip_ce && !bus_req);
endmodule

bind rtc_snap_seq rtc_snap_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .chip_ce   (chip_ce),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .done      (done)
);

// File: tb/rtc_snap_seq_bench.sv
module rtc_snap_seq_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic init_req = 0, get_req = 0, set_req = 0;
  logic [6:0] set_sec = 0, set_min = 0, set_hour = 0, set_day = 0, set_mon = 0, set_year = 0;
  logic [2:0] set_wday = 0;
  logic [6:0] get_sec, get_min, get_hour, get_day, get_mon, get_year;
  logic [3:0] get_wday;
  logic time_valid, err, done, chip_ce, bus_req, bus_we;
  logic [3:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_ack;

  rtc_snap_seq u_rtc_snap_seq (
    .clk(clk), .rst(rst), .init_req(init_req), .get_req(get_req), .set_req(set_req),
    .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour), .set_day(set_day),
    .set_mon(set_mon), .set_year(set_year), .set_wday(set_wday),
    .get_sec(get_sec), .get_min(get_min), .get_hour(get_hour), .get_day(get_day),
    .get_mon(get_mon), .get_year(get_year), .get_wday(get_wday),
    .time_valid(time_valid), .err(err), .done(done), .chip_ce(chip_ce),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // ---------------- chip model ----------------
  logic       xstp = 0;
  int         busy_cfg = 0;
  logic       log_clr = 0;
  logic [3:0] regs [16];
  logic [8:0] oplog [64];
  int nops, n_ctrl_rd, ce_rises;
  logic ce_q;

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      bus_rdata <= '0;
      nops <= 0; n_ctrl_rd <= 0; ce_rises <= 0; ce_q <= 1'b0;
      for (int i = 0; i < 16; i++) regs[i] <= '0;
    end else begin
      ce_q <= chip_ce;
      bus_ack <= 1'b0;
      if (log_clr) begin
        nops <= 0; n_ctrl_rd <= 0; ce_rises <= 0;
      end else begin
        if (chip_ce && !ce_q) ce_rises <= ce_rises + 1;
        if (bus_req && !bus_ack) begin
          bus_ack <= 1'b1;
          if (nops < 64) oplog[nops] <= {bus_we, bus_addr, bus_wdata};
          nops <= nops + 1;
          if (bus_we) begin
            regs[bus_addr] <= bus_wdata;
          end else if (bus_addr == 4'd15) begin
            bus_rdata <= {xstp, 1'b0, (n_ctrl_rd < busy_cfg), 1'b0};
            n_ctrl_rd <= n_ctrl_rd + 1;
          end else begin
            bus_rdata <= regs[bus_addr];
          end
        end
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1;
    @(negedge clk); log_clr = 0;
  endtask

  task automatic pulse(input bit i, input bit s, input bit g);
    @(negedge clk);
    init_req = i; set_req = s; get_req = g;
    @(negedge clk);
    init_req = 0; set_req = 0; get_req = 0;
  endtask

  // R13: wait for done, then check ce low and pulse width
  task automatic wait_done();
    int n = 0;
    while (!done && n < 50000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R13 done seen", int'(done), 1);
    chk(chip_ce == 1'b0, "R13 ce low at done", int'(chip_ce), 0);
    @(negedge clk);
    chk(done == 1'b0, "R13 done one cycle", int'(done), 0);
  endtask

  function automatic int op(input bit we, input int a, input int d);
    return (int'(we) << 8) | (a << 4) | d;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(chip_ce == 0 && bus_req == 0, "R1 ce/req after reset", int'({chip_ce, bus_req}), 0);
    chk(done == 0 && time_valid == 0 && err == 0, "R1 flags after reset",
        int'({done, time_valid, err}), 0);
  endtask

  task automatic t_get_invalid();
    clear_log();
    pulse(0, 0, 1);
    wait_done();
    chk(nops == 0, "R11 no access while invalid", nops, 0);
    chk(ce_rises == 0, "R11 no chip enable while invalid", ce_rises, 0);
  endtask

  task automatic t_init_ok();
    xstp = 0; busy_cfg = 0;
    clear_log();
    pulse(1, 0, 0);
    wait_done();
    chk(time_valid == 1, "R2 valid after clean init", int'(time_valid), 1);
    chk(nops == 1, "R2 single access", nops, 1);
    chk(int'(oplog[0]) == op(0, 15, int'(oplog[0][3:0])), "R2 control read", int'(oplog[0]), op(0, 15, 0));
  endtask

  task automatic t_init_stopped();
    xstp = 1; busy_cfg = 3;
    clear_log();
    pulse(1, 0, 0);
    wait_done();
    chk(time_valid == 0 && err == 0, "R3 flags after adjust", int'({time_valid, err}), 0);
    chk(nops == 7, "R3 access count", nops, 7);
    chk(int'(oplog[1]) == op(1, 14, 0), "R3 timer cleared", int'(oplog[1]), op(1, 14, 0));
    chk(int'(oplog[2]) == op(1, 15, 5), "R3 adjust write", int'(oplog[2]), op(1, 15, 5));
    chk(int'(oplog[6]) == op(1, 15, 4), "R3 base rewrite", int'(oplog[6]), op(1, 15, 4));
  endtask

  task automatic t_init_timeout();
    xstp = 1; busy_cfg = 100000;
    clear_log();
    pulse(1, 0, 0);
    wait_done();
    chk(err == 1, "R4 err on poll limit", int'(err), 1);
    chk(n_ctrl_rd == 1001, "R4 control reads", n_ctrl_rd, 1001);
    chk(nops == 1003, "R4 no base rewrite", nops, 1003);
  endtask

  task automatic do_set(input int s, input int mi, input int h, input int d,
                        input int mo, input int y, input int w, input int busy, input string tag);
    int v [6];
    int base;
    set_sec = 7'(s); set_min = 7'(mi); set_hour = 7'(h); set_day = 7'(d);
    set_mon = 7'(mo); set_year = 7'(y); set_wday = 3'(w);
    v = '{s, mi, h, d, mo, y};
    xstp = 0; busy_cfg = busy;
    clear_log();
    pulse(0, 1, 0);
    wait_done();
    base = 2 * (busy + 1);
    chk(err == 0, {tag, " R5 no error"}, int'(err), 0);
    chk(ce_rises == busy + 1, {tag, " R5 attempts"}, ce_rises, busy + 1);
    chk(int'(oplog[0]) == op(1, 15, 4), {tag, " R5 base write"}, int'(oplog[0]), op(1, 15, 4));
    chk(nops == base + 13, {tag, " R9 access count"}, nops, base + 13);
    for (int f = 0; f < 6; f++) begin
      int r = v[f] % 100;
      chk(int'(oplog[base + 2*f]) == op(1, 2*f, r % 10), {tag, " R9 ones nibble R10"},
          int'(oplog[base + 2*f]), op(1, 2*f, r % 10));
      chk(int'(oplog[base + 2*f + 1]) == op(1, 2*f + 1, r / 10), {tag, " R9 tens nibble R10"},
          int'(oplog[base + 2*f + 1]), op(1, 2*f + 1, r / 10));
    end
    chk(int'(oplog[base + 12]) == op(1, 12, w), {tag, " R9 weekday last"},
        int'(oplog[base + 12]), op(1, 12, w));
    chk(time_valid == 1, {tag, " R12 valid after set"}, int'(time_valid), 1);
  endtask

  task automatic t_get(input int s, input int mi, input int h, input int d,
                       input int mo, input int y, input int w);
    busy_cfg = 0;
    clear_log();
    pulse(0, 0, 1);
    wait_done();
    chk(nops == 15, "R7 access count", nops, 15);
    for (int k = 0; k < 13; k++)
      chk(oplog[2 + k][8:4] == 5'(k), "R7 read order", int'(oplog[2 + k][8:4]), k);
    chk(get_sec == 7'(s) && get_min == 7'(mi), "R8 sec/min", int'(get_sec), s);
    chk(get_hour == 7'(h) && get_day == 7'(d), "R8 hour/day", int'(get_hour), h);
    chk(get_mon == 7'(mo), "R8 month", int'(get_mon), mo);
    chk(get_year == 7'(y), "R8 year R10", int'(get_year), y);
    chk(get_wday == 4'(w), "R8 weekday", int'(get_wday), w);
  endtask

  task automatic t_abandon();
    busy_cfg = 10;
    clear_log();
    pulse(0, 0, 1);
    wait_done();
    chk(err == 1, "R6 err after all busy", int'(err), 1);
    chk(nops == 20 && n_ctrl_rd == 10, "R6 only control accesses", nops, 20);
    chk(ce_rises == 10, "R6 attempts", ce_rises, 10);
    chk(get_sec == 7'd37, "R6 outputs unchanged", int'(get_sec), 37);
  endtask

  task automatic t_priority();
    xstp = 0; busy_cfg = 0;
    clear_log();
    pulse(1, 1, 1);
    wait_done();
    chk(nops == 1, "R14 init wins", nops, 1);
    chk(n_ctrl_rd == 1, "R14 one control read", n_ctrl_rd, 1);
    repeat (4) @(negedge clk);
    chk(nops == 1 && chip_ce == 0, "R14 others dropped", nops, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_get_invalid();
    t_init_ok();
    t_init_stopped();
    t_init_timeout();
    do_set(37, 5, 23, 19, 12, 123, 6, 2, "set1");
    t_get(37, 5, 23, 19, 12, 23, 6);
    t_abandon();
    do_set(8, 59, 0, 31, 1, 99, 0, 9, "set2");
    t_get(8, 59, 0, 31, 1, 99, 0);
    t_priority();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule